// File: doc/BRIEF.md
# Crystal Oscillator Bias Trim Controller

This block chooses and keeps the bias trim code for a crystal oscillator. It sees the oscillator only through two comparator flags. `hi_i` means the bias is too strong. `lo_i` means the bias is strong enough to sustain oscillation.

A start pulse begins the bring-up sequence. If the stored trim input holds the all-ones value, the stored code is taken as unset, and a binary search over the trim code finds the smallest code for which `lo_i` reads 1. A saturating safety margin is then added. A stored code that is not all ones is loaded directly and the search is skipped.

After that, a correction loop walks the code until both flags are in range or a limit is reached. When the final code has settled, the crystal select output goes high. Each later one-cycle check pulse makes one correction to the running code.

Every trim write is followed by a settle window of `SETTLE_CYC` clock cycles before the flags are read. The parameter is the clock-domain count that matches the oscillator's 1.5 ms settle time.

Top module: `xtal_bias_trim`

## Requirements
- R1: After reset `trim_o`=0, `busy_o`=0 and `xtal_sel_o`=0. While the block is idle, `check_i` has no effect.
- R2: After every write of a new trim value, the comparator flags are sampled no earlier than `SETTLE_CYC` cycles later.
- R3: A start with `stored_trim_i`=4'hF runs an MSB-first search. Each bit is set, the code settles, and the bit is cleared again if `lo_i`=1. The search ends on the smallest code with `lo_i`=1.
- R4: When the search ends, the final code is settled once more. If `lo_i`=0, the code is raised by one.
- R5: After the search, a margin of 2 is added. The result becomes the maximum code 15 whenever the code is 13 or more.
- R6: A start with any other `stored_trim_i` loads that code directly, with no search.
- R7: The correction loop lowers the code by one while `hi_i`=1, and only while the code is above the floor of 2. It repeats while `hi_i`=1 or `lo_i`=0.
- R8: The correction loop stops once the code reaches 15 or the floor of 2. If `lo_i` was 0 at exit, or the code is below 2, the saturating margin of 2 is added.
- R9: `busy_o` is high from the cycle after start until `xtal_sel_o` rises. The two are never high together, and `xtal_sel_o` stays high until reset.
- R10: A check pulse while selected lowers the code by one when `hi_i`=1.
- R11: A check pulse while selected with `lo_i`=0 raises the code by one and then adds the saturating margin of 2.
- R12: After a check, the code is never below 2.
- R13: `check_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin bring-up (idle only) |
| stored_trim_i | input | 4 | Stored code; all ones means unset |
| hi_i | input | 1 | Comparator: bias too high |
| lo_i | input | 1 | Comparator: bias sufficient |
| check_i | input | 1 | Run-time check pulse |
| trim_o | output | 4 | Current bias trim code |
| busy_o | output | 1 | Bring-up in progress |
| xtal_sel_o | output | 1 | Select crystal as clock source |

## Verification
Some properties are checked on every cycle:
- `busy_o` and `xtal_sel_o` are exclusive, and select is sticky.
- The code holds still through each settle window, and idle ignores the check pulse.
- The floor holds after every run-time check.
- The settle counter stays in range.

The bench's oscillator model only updates its flags a fixed lag after each trim change. Because of that, only the directed scenarios can show that the search, margin, correction loop and check rules land on the right final codes when the flags are read after settling.

// File: rtl/xbt_pkg.sv
package xbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SRCH, ST_FIX, ST_SWEVAL, ST_POST, ST_DONE
  } xbt_state_e;
endpackage

// File: rtl/xbt_settle_timer.sv
module xbt_settle_timer #(
  parameter int SETTLE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || done_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == CW'(SETTLE_CYC - 1));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(SETTLE_CYC));
endmodule

// File: rtl/xbt_trim_rules.sv
module xbt_trim_rules #(
  parameter int TRIM_W = 4,
  parameter int OFFSET = 2,
  parameter int FLOOR  = 2
) (
  input  logic [TRIM_W-1:0] trim_i,
  input  logic [TRIM_W-1:0] mask_i,
  input  logic              hi_i,
  input  logic              lo_i,
  input  logic              lo_seen_i,
  output logic [TRIM_W-1:0] srch_res_o,
  output logic [TRIM_W-1:0] fix_res_o,
  output logic [TRIM_W-1:0] sw_res_o,
  output logic              sw_dec_o,
  output logic              sw_more_o,
  output logic              post_apply_o,
  output logic [TRIM_W-1:0] post_res_o,
  output logic [TRIM_W-1:0] chk_res_o
);
  localparam int MAXV = (1 << TRIM_W) - 1;
  localparam logic [TRIM_W-1:0] MAX_C = TRIM_W'(MAXV);
  localparam logic [TRIM_W-1:0] FLR_C = TRIM_W'(FLOOR);
  localparam logic [TRIM_W-1:0] SAT_C = TRIM_W'(MAXV - OFFSET);

  function automatic logic [TRIM_W-1:0] add_off(input logic [TRIM_W-1:0] t);
    return (t < SAT_C) ? t + TRIM_W'(OFFSET) : MAX_C;
  endfunction
  function automatic logic [TRIM_W-1:0] inc_sat(input logic [TRIM_W-1:0] t);
    return (t == MAX_C) ? t : t + 1'b1;
  endfunction
  function automatic logic [TRIM_W-1:0] dec_sat(input logic [TRIM_W-1:0] t);
    return (t == '0) ? t : t - 1'b1;
  endfunction

  logic [TRIM_W-1:0] sw_inc, chk_a, chk_b;

  always_comb begin
    srch_res_o   = lo_i ? (trim_i & ~mask_i) : trim_i;
    fix_res_o    = add_off(lo_i ? trim_i : inc_sat(trim_i));
    sw_inc       = lo_i ? trim_i : inc_sat(trim_i);
    sw_dec_o     = hi_i && (sw_inc > FLR_C);
    sw_res_o     = sw_dec_o ? sw_inc - 1'b1 : sw_inc;
    sw_more_o    = (hi_i || !lo_i) && (sw_res_o < MAX_C) && (sw_res_o > FLR_C);
    post_apply_o = !lo_seen_i || (trim_i < FLR_C);
    post_res_o   = add_off(trim_i);
    chk_a        = hi_i ? dec_sat(trim_i) : trim_i;
    chk_b        = lo_i ? chk_a : add_off(inc_sat(chk_a));
    chk_res_o    = (chk_b < FLR_C) ? FLR_C : chk_b;
  end
endmodule

// File: rtl/xtal_bias_trim.sv
module xtal_bias_trim
  import xbt_pkg::*;
#(
  parameter int TRIM_W     = 4,
  parameter int OFFSET     = 2,
  parameter int FLOOR      = 2,
  parameter int SETTLE_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TRIM_W-1:0] stored_trim_i,
  input  logic              hi_i,
  input  logic              lo_i,
  input  logic              check_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              busy_o,
  output logic              xtal_sel_o
);
  localparam logic [TRIM_W-1:0] UNSET = '1;
  localparam logic [TRIM_W-1:0] MSB   = TRIM_W'(1) << (TRIM_W - 1);

  xbt_state_e        state_q, ret_q;
  logic [TRIM_W-1:0] trim_q, mask_q;
  logic              lo_q, last_q, tmr_done;
  logic [TRIM_W-1:0] srch_res, fix_res, sw_res, post_res, chk_res;
  logic              sw_dec, sw_more, post_apply;

  xbt_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(state_q == ST_WAIT), .done_o(tmr_done)
  );

  xbt_trim_rules #(.TRIM_W(TRIM_W), .OFFSET(OFFSET), .FLOOR(FLOOR)) u_rules (
    .trim_i(trim_q), .mask_i(mask_q), .hi_i(hi_i), .lo_i(lo_i),
    .lo_seen_i(lo_q),
    .srch_res_o(srch_res), .fix_res_o(fix_res), .sw_res_o(sw_res),
    .sw_dec_o(sw_dec), .sw_more_o(sw_more), .post_apply_o(post_apply),
    .post_res_o(post_res), .chk_res_o(chk_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      trim_q  <= '0;
      mask_q  <= '0;
      lo_q    <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          last_q  <= 1'b0;
          if (stored_trim_i == UNSET) begin
            trim_q <= MSB;
            mask_q <= MSB;
            ret_q  <= ST_SRCH;
          end else begin
            trim_q <= stored_trim_i;
            ret_q  <= ST_SWEVAL;
          end
        end
        ST_WAIT: if (tmr_done) state_q <= ret_q;
        ST_SRCH: begin
          state_q <= ST_WAIT;
          if (mask_q[0]) begin
            trim_q <= srch_res;      // settle final code before LO test
            ret_q  <= ST_FIX;
          end else begin
            trim_q <= srch_res | (mask_q >> 1);
            mask_q <= mask_q >> 1;
          end
        end
        ST_FIX: begin
          trim_q  <= fix_res;
          ret_q   <= ST_SWEVAL;
          state_q <= ST_WAIT;
        end
        ST_SWEVAL: begin
          trim_q  <= sw_res;
          lo_q    <= lo_i;
          if (sw_dec) last_q <= 1'b1;
          state_q <= sw_more ? ST_WAIT : ST_POST;
        end
        ST_POST: begin
          ret_q <= ST_DONE;
          if (post_apply) begin
            trim_q  <= post_res;
            state_q <= ST_WAIT;
          end else if (last_q) begin
            state_q <= ST_WAIT;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: if (check_i) trim_q <= chk_res;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign trim_o     = trim_q;
  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign xtal_sel_o = (state_q == ST_DONE);

  p_busy_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !xtal_sel_o);
  p_sel_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xtal_sel_o |=> xtal_sel_o);
  p_settle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !tmr_done) |=> $stable(trim_o));
  p_idle_ignore_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !xtal_sel_o && !start_i) |=> $stable(trim_o));
  p_floor_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xtal_sel_o && check_i) |=> (trim_o >= TRIM_W'(FLOOR)));
endmodule

// File: tb/xtal_bias_trim_test.sv
module xtal_bias_trim_test;
  localparam int SETTLE = 64;
  localparam int LAG    = SETTLE - 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, check = 1'b0;
  logic [3:0] stored = 4'hF;
  logic [3:0] trim;
  logic busy, sel;
  logic hi_m = 1'b0, lo_m = 1'b0;
  logic [3:0] prev_trim = 4'h0;
  int age = 0;
  int lo_th = 0, hi_th = 15;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  xtal_bias_trim #(.SETTLE_CYC(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stored_trim_i(stored),
    .hi_i(hi_m), .lo_i(lo_m), .check_i(check),
    .trim_o(trim), .busy_o(busy), .xtal_sel_o(sel)
  );

  // Oscillator model: flags follow the trim only after LAG stable cycles
  always @(posedge clk) begin
    if (trim != prev_trim) age <= 0;
    else if (age < LAG) age <= age + 1;
    prev_trim <= trim;
    if (age >= LAG) begin
      lo_m <= (int'(trim) >= lo_th);
      hi_m <= (int'(trim) > hi_th);
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; check = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(SETTLE + 4);
  endtask

  task automatic kick(input logic [3:0] s);
    stored = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_sel();
    for (int i = 0; i < 5000 && !sel; i++) @(negedge clk);
    chk(sel, "R9 select asserted", sel, 1);
    chk(!busy, "R9 busy low at select", busy, 0);
  endtask

  task automatic pulse_check();
    check = 1'b1;
    @(negedge clk);
    check = 1'b0;
  endtask

  task automatic set_th(input int lo, input int hi);
    lo_th = lo; hi_th = hi;
    cyc(4);
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk(trim == 4'd0, "R1 reset trim", trim, 0);
    chk(!busy && !sel, "R1 reset busy/sel", {busy, sel}, 0);
    set_th(15, 0);
    pulse_check();
    cyc(2);
    chk(trim == 4'd0, "R1 idle ignores check", trim, 0);
  endtask

  task automatic t_search_mid();
    do_reset();
    set_th(5, 12);
    kick(4'hF);
    chk(busy && !sel, "R9 busy after start", {busy, sel}, 2);
    wait_sel();
    chk(trim == 4'd7, "R3 R4 R5 R2 search result", trim, 7);
    set_th(0, 5);
    pulse_check();
    chk(trim == 4'd6, "R10 check hi decrements", trim, 6);
    cyc(SETTLE + 8);
    set_th(10, 15);
    pulse_check();
    chk(trim == 4'd9, "R11 check lo raises with margin", trim, 9);
    cyc(SETTLE + 8);
    set_th(15, 15);
    pulse_check();
    chk(trim == 4'd12, "R11 check lo again", trim, 12);
    cyc(SETTLE + 8);
    pulse_check();
    chk(trim == 4'd15, "R11 check margin saturates", trim, 15);
    chk(sel, "R9 select sticky", sel, 1);
  endtask

  task automatic t_stored_high();
    do_reset();
    set_th(3, 6);
    kick(4'd9);
    cyc(10);
    pulse_check();       // R13: ignored while busy
    wait_sel();
    chk(trim == 4'd6, "R6 R7 R13 stored walk down", trim, 6);
  endtask

  task automatic t_stored_low();
    do_reset();
    set_th(4, 12);
    kick(4'd1);
    wait_sel();
    chk(trim == 4'd4, "R8 stop at floor then margin", trim, 4);
  endtask

  task automatic t_stored_top();
    do_reset();
    set_th(15, 15);
    kick(4'd14);
    wait_sel();
    chk(trim == 4'd15, "R8 R5 stop at max saturated", trim, 15);
  endtask

  task automatic t_search_top();
    do_reset();
    set_th(14, 15);
    kick(4'hF);
    wait_sel();
    chk(trim == 4'd15, "R4 R5 search near top", trim, 15);
  endtask

  task automatic t_search_zero();
    do_reset();
    set_th(0, 10);
    kick(4'hF);
    wait_sel();
    chk(trim == 4'd2, "R3 R5 search reaches zero", trim, 2);
    set_th(0, 0);
    pulse_check();
    chk(trim == 4'd2, "R12 floor after check", trim, 2);
    cyc(SETTLE + 8);
    set_th(15, 0);
    pulse_check();
    chk(trim == 4'd4, "R10 R11 both flags", trim, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_search_mid();
    t_stored_high();
    t_stored_low();
    t_stored_top();
    t_search_top();
    t_search_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule